// File: doc/BRIEF.md
# SMI Event Status and Enable Register

This block is the 32-bit legacy-support control and status word of a USB host controller. It records events that firmware in system-management mode must handle, and it raises one SMI request line whenever an event is present and its enable is set. Three events are captured in sticky bits. One marks a write to the base-address register. One marks a write to the command register. One marks any change of the OS-owned semaphore level, rising or falling. Software clears each sticky bit by writing 1 to it.

Six more status bits are live read-only copies of the host controller's interrupt status bits 5..0. They can be cleared only at the controller's own status register, never here. The lower sixteen bits hold read/write enables. Enable bit i gates status bit 16+i.

The block has one reset, which is the suspend-well reset. Warm resets and core-well resets are not connected to it, so the captured events survive them. The register reads as all zeros after that reset, provided the live status inputs are zero.

Top module: `smi_evt_reg`

## Requirements
- R1: After `rst_n` is asserted, `rd_data` reads 0x00000000 and `smi_req` is 0 while `hc_sts` is zero.
- R2: A cycle with `bar_wr_stb` high sets bit 31, and it reads 1 from the next cycle on. It then holds until it is cleared.
- R3: A cycle with `cmd_wr_stb` high sets bit 30, and it reads 1 from the next cycle on. It then holds until it is cleared.
- R4: The semaphore `os_sem` is sampled every cycle. A change from 0 to 1, or from 1 to 0, sets bit 29 from the next cycle on. The sampled level is 0 after reset.
- R5: A write (`wr_en` high) with a 1 in bit 31, 30 or 29 clears that bit in the next cycle. A 0 in those positions leaves the bit unchanged.
- R6: Bits 28..22 always read 0, whatever is written.
- R7: Bits 21..16 read `hc_sts[5:0]` in the same cycle. Writes to these positions have no effect.
- R8: Bits 15..0 are enables. A write loads them from `wr_data[15:0]` and they read back from the next cycle on.
- R9: `smi_req` is combinationally the OR over i in 0..15 of (bit 16+i AND bit i) of the read value.
- R10: If a set event and a write-1 clear reach the same sticky bit in the same cycle, the bit reads 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low suspend-well reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| bar_wr_stb | input | 1 | Base-address register was written this cycle |
| cmd_wr_stb | input | 1 | Command register was written this cycle |
| os_sem | input | 1 | OS-owned semaphore level |
| hc_sts | input | 6 | Live controller interrupt status bits 5..0 |
| rd_data | output | 32 | Current register value |
| smi_req | output | 1 | SMI request |

## Verification
The assertions assume that `os_sem` is low for as long as reset is held. They also assume that `hc_sts` changes only between clock edges. The bench holds every input at zero during reset. It changes inputs only just after a falling edge, so each transition falls inside one sampled cycle.

The stimulus sweeps all 64 mirrored status values, every single-bit enable, and all pairs of sticky state and sticky enable. Semaphore toggles, clears and set/clear collisions are applied one at a time.

// File: rtl/smi_evt_pkg.sv
package smi_evt_pkg;
  localparam int REG_W   = 32;
  localparam int EN_W    = REG_W / 2;
  localparam int MIR_W   = 6;
  localparam int STK_N   = 3;
  localparam int STK_LSB = REG_W - STK_N;          // 29
  localparam int MIR_LSB = EN_W;                   // 16
  localparam int RSV_W   = STK_LSB - MIR_LSB - MIR_W; // 7

  // status half ANDed with enable half, reduced to one request
  function automatic logic smi_reduce(input logic [EN_W-1:0] sts,
                                      input logic [EN_W-1:0] en);
    return |(sts & en);
  endfunction

  // next value of a sticky bit: set dominates clear
  function automatic logic sticky_next(input logic q, input logic set,
                                       input logic clr);
    return set | (q & ~clr);
  endfunction
endpackage

// File: rtl/smi_sticky_bit.sv
module smi_sticky_bit
  import smi_evt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= sticky_next(q, set_i, clr_i);
  end
  assign q_o = q;
endmodule

// File: rtl/smi_sem_edge.sv
module smi_sem_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic chg_o
);
  logic lvl_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_i;
  end
  assign chg_o = lvl_i ^ lvl_q;
endmodule

// File: rtl/smi_req_gate.sv
module smi_req_gate
  import smi_evt_pkg::*;
(
  input  logic [EN_W-1:0] sts_i,
  input  logic [EN_W-1:0] en_i,
  output logic            req_o
);
  assign req_o = smi_reduce(sts_i, en_i);
endmodule

// File: rtl/smi_evt_reg.sv
module smi_evt_reg
  import smi_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             bar_wr_stb,
  input  logic             cmd_wr_stb,
  input  logic             os_sem,
  input  logic [MIR_W-1:0] hc_sts,
  output logic [REG_W-1:0] rd_data,
  output logic             smi_req
);
  logic             sem_toggle;
  logic [STK_N-1:0] evt_set;
  logic [STK_N-1:0] evt_clr;
  logic [STK_N-1:0] evt_q;
  logic [EN_W-1:0]  en_q;
  logic [EN_W-1:0]  status_hi;

  smi_sem_edge u_sem (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (os_sem),
    .chg_o (sem_toggle)
  );

  // index 0 -> bit 29 (semaphore), 1 -> bit 30 (command), 2 -> bit 31 (base address)
  assign evt_set = {bar_wr_stb, cmd_wr_stb, sem_toggle};
  assign evt_clr = wr_en ? wr_data[REG_W-1:STK_LSB] : '0;

  for (genvar k = 0; k < STK_N; k++) begin : g_stk
    smi_sticky_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (evt_set[k]),
      .clr_i (evt_clr[k]),
      .q_o   (evt_q[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= wr_data[EN_W-1:0];
  end

  assign status_hi = {evt_q, {RSV_W{1'b0}}, hc_sts};
  assign rd_data   = {status_hi, en_q};

  smi_req_gate u_gate (
    .sts_i (status_hi),
    .en_i  (en_q),
    .req_o (smi_req)
  );
endmodule

// File: rtl/smi_evt_chk.sv
module smi_evt_chk
  import smi_evt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic             bar_wr_stb,
  input logic             cmd_wr_stb,
  input logic             sem_toggle,
  input logic [MIR_W-1:0] hc_sts,
  input logic [REG_W-1:0] rd_data,
  input logic             smi_req
);
  p_bar_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bar_wr_stb |=> rd_data[31]);
  p_bar_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bar_wr_stb && !(wr_en && wr_data[31])) |=> rd_data[31] == $past(rd_data[31]));
  p_cmd_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_stb |=> rd_data[30]);
  p_sem_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sem_toggle |=> rd_data[29]);
  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[31] && !bar_wr_stb) |=> !rd_data[31]);
  p_rsvd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[28:22] == '0);
  p_mirror_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[21:16] == hc_sts);
  p_en_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[15:0] == $past(wr_data[15:0]));
  p_smi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req == |(rd_data[31:16] & rd_data[15:0]));
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_stb && wr_en && wr_data[30]) |=> rd_data[30]);
endmodule

bind smi_evt_reg smi_evt_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .bar_wr_stb (bar_wr_stb),
  .cmd_wr_stb (cmd_wr_stb),
  .sem_toggle (sem_toggle),
  .hc_sts     (hc_sts),
  .rd_data    (rd_data),
  .smi_req    (smi_req)
);

// File: tb/smi_evt_reg_tb.sv
module smi_evt_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        bar_wr_stb = 1'b0;
  logic        cmd_wr_stb = 1'b0;
  logic        os_sem = 1'b0;
  logic [5:0]  hc_sts = '0;
  logic [31:0] rd_data;
  logic        smi_req;

  int n_vec = 0;
  int n_bad = 0;
  logic [2:0]  m_stk = '0;
  logic [15:0] m_en = '0;
  logic        m_sem = 1'b0;

  always #5 clk = ~clk;

  smi_evt_reg u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .bar_wr_stb(bar_wr_stb), .cmd_wr_stb(cmd_wr_stb), .os_sem(os_sem),
    .hc_sts(hc_sts), .rd_data(rd_data), .smi_req(smi_req)
  );

  function automatic logic [31:0] exp_rd();
    return {m_stk, 7'b0, hc_sts, m_en};
  endfunction

  task automatic compare(input string req);
    logic [31:0] er;
    logic        es;
    er = exp_rd();
    es = 1'b0;
    for (int i = 0; i < 16; i++) es = es | (er[16+i] & er[i]);
    n_vec++;
    if (rd_data !== er || smi_req !== es) begin
      n_bad++;
      $display("FAIL %s: rd_data=%h smi_req=%b expected rd_data=%h smi_req=%b",
               req, rd_data, smi_req, er, es);
    end
  endtask

  // one clock: update model from driven inputs, check at next falling edge
  task automatic step(input string req);
    logic [2:0] clr;
    logic [2:0] set;
    clr = wr_en ? wr_data[31:29] : 3'b0;
    set = {bar_wr_stb, cmd_wr_stb, os_sem ^ m_sem};
    m_stk = set | (m_stk & ~clr);
    if (wr_en) m_en = wr_data[15:0];
    m_sem = os_sem;
    @(negedge clk);
    compare(req);
    wr_en = 1'b0; wr_data = '0; bar_wr_stb = 1'b0; cmd_wr_stb = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d, input string req);
    wr_en = 1'b1; wr_data = d;
    step(req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 reset value");
    rst_n = 1'b1;
    step("R1 idle after reset");

    // R7/R9: mirror sweep with low six enables on; writes to 21:16 ignored
    wr(32'h0000_003F, "R8 enable load");
    for (int v = 0; v < 64; v++) begin
      hc_sts = v[5:0];
      wr({10'b0, ~v[5:0], 16'h003F}, "R7 mirror ignores writes");
      step("R7 mirror hold");
    end

    // R8/R9: each single enable with all mirrors high
    hc_sts = 6'h3F;
    for (int i = 0; i < 16; i++) begin
      wr(32'h1 << i, "R8 single enable readback");
      step("R9 request from single enable");
    end
    hc_sts = '0;
    wr(32'h0, "R8 enables cleared");

    // R2/R3 sticky capture and hold
    bar_wr_stb = 1'b1; step("R2 base-address write sets bit 31");
    repeat (3) step("R2 bit 31 holds");
    cmd_wr_stb = 1'b1; step("R3 command write sets bit 30");
    repeat (3) step("R3 bit 30 holds");

    // R5 zero write leaves them, one write clears
    wr(32'h0000_0000, "R5 write 0 keeps sticky bits");
    wr(32'h8000_0000, "R5 clear bit 31 only");
    wr(32'h4000_0000, "R5 clear bit 30");

    // R4 semaphore both directions
    os_sem = 1'b1; step("R4 rising semaphore sets bit 29");
    step("R4 steady semaphore");
    wr(32'h2000_0000, "R5 clear bit 29");
    step("R4 no change no set");
    os_sem = 1'b0; step("R4 falling semaphore sets bit 29");
    wr(32'h2000_0000, "R5 clear bit 29 again");

    // R6 reserved bits
    wr(32'h1FC0_0000, "R6 reserved bits read zero");

    // R10 set wins over clear
    bar_wr_stb = 1'b1; cmd_wr_stb = 1'b1;
    wr(32'hC000_0000, "R10 set wins over clear");
    os_sem = 1'b1;
    wr(32'h2000_0000, "R10 semaphore set wins over clear");
    wr(32'hE000_0000, "R5 clear all sticky");

    // R9 sticky state x sticky enable sweep
    for (int s = 0; s < 8; s++) begin
      for (int e = 0; e < 8; e++) begin
        wr(32'hE000_0000, "R5 clear before combo");
        bar_wr_stb = s[2]; cmd_wr_stb = s[1];
        if (s[0]) os_sem = ~os_sem;
        wr({16'b0, e[2:0], 13'b0}, "R9 sticky enable combo");
        step("R9 sticky enable combo hold");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule